// File: doc/BRIEF.md
# Shadow Region Attribute Decoder

This block holds five chipset configuration registers. Software reaches them through an index port and a data port on the I/O bus. From their contents the block decides, for any memory page in the upper 256 KB of the first megabyte, where reads come from and where writes go. Reads come from internal RAM or from the external bus. Writes go to internal RAM, go to the external bus, or are blocked.

The region from 0xC0000 to 0xEFFFF is split into twelve 16 KB segments, and the top 64 KB area at 0xF0000 has its own rules. Each segment's outcome comes from three bits: a per-segment enable, a per-group ROM-shadow enable and a per-group write mode. A global copy bit then decides whether the writes of a write-enabled shadow reach internal RAM.

The memory side takes a 4 KB page number (address bits 19:12) and answers combinationally. Pages below 0xC0000 are not claimed. A flag tells a neighbouring remap block when any segment at or above 0xD0000 is shadowed. A further output carries the halt-reset control bit.

Top module: `shadow_attr_decoder`

## Requirements
- R1: An I/O write to port 0x22 loads the index. `io_rdata` shows the indexed register whenever `io_addr` is 0x24, and shows 0xFF for any other `io_addr`.
- R2: Only indexes 0x10 to 0x14 store data written through port 0x24. Reading back any other index gives 0x00, even after a write to it.
- R3: After reset, index 0x10 reads 0x3F and index 0x11 reads 0xF0. Indexes 0x12, 0x13 and 0x14 read 0x00, and `shadow_high` and `halt_reset_en` are 0.
- R4: Output encodings: `rd_src` is 0 none, 1 internal RAM, 2 external, 3 external-any; `wr_tgt` is 0 blocked, 1 internal RAM, 2 external. With reg 0x11 bit 7 set, every page 0xF0 to 0xFF gives `rd_src`=3 and `wr_tgt`=1.
- R5: With reg 0x11 bit 7 clear, pages 0xF0 to 0xFF give `rd_src`=1. Page 0xF0 gives `wr_tgt`=1 if reg 0x14 bit 7 is set and 0 if it is clear. Pages 0xF1 to 0xFF always give `wr_tgt`=0.
- R6: Segment s = (page-0xC0)/4 (0 to 11) is in group g = s/4. Its enable is reg 0x13 bit s+4 for s<4 and reg 0x12 bit s-4 otherwise. Its ROM enable is reg 0x11 bit g+4, its mode is reg 0x11 bit g, and the copy bit is reg 0x11 bit 3. A segment with both enables set gives `rd_src`=1. Its `wr_tgt` is 0 when the mode is clear, 1 when mode and copy are both set, and 2 when the mode is set and copy is clear.
- R7: A segment that lacks either enable gives `wr_tgt`=0. It gives `rd_src`=2 below page 0xE0 and `rd_src`=3 from page 0xE0 on.
- R8: `shadow_high` is 1 exactly when some segment with s>=4 has both its enable and its ROM enable set.
- R9: `halt_reset_en` equals bit 6 of the last value written to index 0x14.
- R10: Pages below 0xC0 give `claimed`=0, `rd_src`=0 and `wr_tgt`=0. Every page from 0xC0 up gives `claimed`=1.
- R11: A data-port write changes the outputs from the rising clock edge on which it is sampled. Before that edge the outputs keep their old values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| io_wr | input | 1 | I/O write strobe |
| io_addr | input | 16 | I/O port address |
| io_wdata | input | 8 | I/O write data |
| io_rdata | output | 8 | I/O read data (combinational) |
| mem_page | input | 8 | Memory address bits 19:12 |
| claimed | output | 1 | Page lies in the decoded range |
| rd_src | output | 2 | Read source for the page |
| wr_tgt | output | 2 | Write target for the page |
| shadow_high | output | 1 | A segment at or above 0xD0000 is shadowed |
| halt_reset_en | output | 1 | Halt-reset control bit |

## Verification
The assertions take two things for granted. `mem_page` really is address bits 19:12, and the I/O inputs settle well before each rising edge, with `io_wr` held for exactly one sampled edge. The bench drives every input on the falling edge and returns `io_wr` low on the next falling edge, so each write is seen on one edge only. It then sweeps all 256 pages under dozens of register patterns. These patterns reach both states of the copy bit, of the top-area select and of the low-4 KB write enable.

// File: rtl/shadow_attr_decoder.sv
module shadow_attr_decoder #(
  parameter logic [15:0] IDX_PORT  = 16'h0022,
  parameter logic [15:0] DATA_PORT = 16'h0024
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        io_wr,
  input  logic [15:0] io_addr,
  input  logic [7:0]  io_wdata,
  output logic [7:0]  io_rdata,
  input  logic [7:0]  mem_page,
  output logic        claimed,
  output logic [1:0]  rd_src,
  output logic [1:0]  wr_tgt,
  output logic        shadow_high,
  output logic        halt_reset_en
);
  localparam logic [1:0] RD_NONE = 2'd0, RD_INT = 2'd1, RD_EXT = 2'd2, RD_EXTANY = 2'd3;
  localparam logic [1:0] WR_BLOCK = 2'd0, WR_INT = 2'd1, WR_EXT = 2'd2;
  localparam int SEGS = 12;

  logic [7:0] idx, r10, r11, r12, r13, r14, sel;

  wire data_wr = io_wr && (io_addr == DATA_PORT);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      idx <= 8'h00;
      r10 <= 8'h3F;
      r11 <= 8'hF0;
      r12 <= 8'h00;
      r13 <= 8'h00;
      r14 <= 8'h00;
    end else begin
      if (io_wr && io_addr == IDX_PORT) idx <= io_wdata;
      if (data_wr) begin
        case (idx)
          8'h10: r10 <= io_wdata;
          8'h11: r11 <= io_wdata;
          8'h12: r12 <= io_wdata;
          8'h13: r13 <= io_wdata;
          8'h14: r14 <= io_wdata;
          default: ;
        endcase
      end
    end
  end

  always_comb begin
    case (idx)
      8'h10: sel = r10;
      8'h11: sel = r11;
      8'h12: sel = r12;
      8'h13: sel = r13;
      8'h14: sel = r14;
      default: sel = 8'h00;
    endcase
  end

  assign io_rdata      = (io_addr == DATA_PORT) ? sel : 8'hFF;
  assign halt_reset_en = r14[6];

  wire [SEGS-1:0] seg_en = {r12, r13[7:4]};
  logic [SEGS-1:0] shadowed;

  for (genvar i = 0; i < SEGS; i++) begin : g_seg
    assign shadowed[i] = seg_en[i] & r11[4 + i/4];
  end

  assign shadow_high = |shadowed[SEGS-1:4];

  wire       in_opt = (mem_page[7:6] == 2'b11);
  wire       in_top = (mem_page[7:4] == 4'hF);
  wire [3:0] seg    = mem_page[5:2];
  wire [1:0] grp    = mem_page[5:4];

  assign claimed = in_opt;

  always_comb begin
    rd_src = RD_NONE;
    wr_tgt = WR_BLOCK;
    if (in_top) begin
      if (r11[7]) begin
        rd_src = RD_EXTANY;
        wr_tgt = WR_INT;
      end else begin
        rd_src = RD_INT;
        wr_tgt = (mem_page[3:0] == 4'h0 && r14[7]) ? WR_INT : WR_BLOCK;
      end
    end else if (in_opt) begin
      if (shadowed[seg]) begin
        rd_src = RD_INT;
        if (!r11[{1'b0, grp}]) wr_tgt = WR_BLOCK;
        else if (r11[3])       wr_tgt = WR_INT;
        else                   wr_tgt = WR_EXT;
      end else begin
        rd_src = grp[1] ? RD_EXTANY : RD_EXT;
      end
    end
  end
endmodule

module shadow_attr_decoder_chk #(
  parameter logic [15:0] DATA_PORT = 16'h0024
) (
  input logic        clk,
  input logic        rst_n,
  input logic        io_wr,
  input logic [15:0] io_addr,
  input logic [7:0]  io_wdata,
  input logic [7:0]  io_rdata,
  input logic [7:0]  mem_page,
  input logic        claimed,
  input logic [1:0]  rd_src,
  input logic [1:0]  wr_tgt,
  input logic        shadow_high,
  input logic        halt_reset_en,
  input logic [7:0]  idx
);
  AST_OTHER_PORT_FF: assert property (@(posedge clk) disable iff (!rst_n)
    io_addr != DATA_PORT |-> io_rdata == 8'hFF); // R1

  AST_UNCLAIMED_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    !claimed |-> (rd_src == 2'd0 && wr_tgt == 2'd0 && mem_page < 8'hC0)); // R10

  AST_EXT_WRITE_SHADOWED: assert property (@(posedge clk) disable iff (!rst_n)
    wr_tgt == 2'd2 |-> (rd_src == 2'd1 && mem_page >= 8'hC0 && mem_page < 8'hF0)); // R6

  AST_EXTANY_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
    rd_src == 2'd3 |-> mem_page >= 8'hE0); // R7

  AST_EXT_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    rd_src == 2'd2 |-> (mem_page >= 8'hC0 && mem_page < 8'hE0 && wr_tgt == 2'd0)); // R7

  AST_TOP_TAIL_LOCKED: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_page > 8'hF0 && rd_src == 2'd1) |-> wr_tgt == 2'd0); // R5

  AST_HIGH_SHADOW_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_src == 2'd1 && mem_page >= 8'hD0 && mem_page < 8'hF0) |-> shadow_high); // R8

  AST_HALT_LATCH: assert property (@(posedge clk) disable iff (!rst_n)
    (io_wr && io_addr == DATA_PORT && idx == 8'h14) |=> halt_reset_en == $past(io_wdata[6])); // R9
endmodule

bind shadow_attr_decoder shadow_attr_decoder_chk #(.DATA_PORT(DATA_PORT)) u_chk (
  .clk(clk), .rst_n(rst_n), .io_wr(io_wr), .io_addr(io_addr), .io_wdata(io_wdata),
  .io_rdata(io_rdata), .mem_page(mem_page), .claimed(claimed), .rd_src(rd_src),
  .wr_tgt(wr_tgt), .shadow_high(shadow_high), .halt_reset_en(halt_reset_en), .idx(idx)
);

// File: tb/shadow_attr_decoder_test.sv
module shadow_attr_decoder_test;
  localparam logic [15:0] IDXP = 16'h0022, DATP = 16'h0024;

  logic clk = 1'b0, rst_n = 1'b0, io_wr = 1'b0;
  logic [15:0] io_addr = 16'h0080;
  logic [7:0]  io_wdata = 8'h00, mem_page = 8'h00;
  logic [7:0]  io_rdata;
  logic        claimed, shadow_high, halt_reset_en;
  logic [1:0]  rd_src, wr_tgt;

  int checks = 0, fails = 0;
  logic [7:0] m11 = 8'hF0, m12 = 8'h00, m13 = 8'h00, m14 = 8'h00;

  always #10 clk = ~clk;

  shadow_attr_decoder uut (
    .clk(clk), .rst_n(rst_n), .io_wr(io_wr), .io_addr(io_addr), .io_wdata(io_wdata),
    .io_rdata(io_rdata), .mem_page(mem_page), .claimed(claimed), .rd_src(rd_src),
    .wr_tgt(wr_tgt), .shadow_high(shadow_high), .halt_reset_en(halt_reset_en)
  );

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic io_write(input logic [15:0] a, input logic [7:0] d);
    @(negedge clk);
    io_wr = 1'b1; io_addr = a; io_wdata = d;
    @(negedge clk);
    io_wr = 1'b0; io_addr = 16'h0080;
  endtask

  task automatic setreg(input logic [7:0] i, input logic [7:0] v);
    io_write(IDXP, i);
    io_write(DATP, v);
    case (i)
      8'h11: m11 = v;
      8'h12: m12 = v;
      8'h13: m13 = v;
      8'h14: m14 = v;
      default: ;
    endcase
  endtask

  task automatic rdreg(input logic [7:0] i, output logic [7:0] v);
    io_write(IDXP, i);
    io_addr = DATP;
    #2 v = io_rdata;
    io_addr = 16'h0080;
  endtask

  function automatic logic [4:0] expect_attr(input logic [7:0] p);
    int s;
    bit en, rom, mode;
    if (p >= 8'hF0) begin
      if (m11[7]) return {1'b1, 2'd3, 2'd1};
      return {1'b1, 2'd1, (p == 8'hF0 && m14[7]) ? 2'd1 : 2'd0};
    end
    if (p < 8'hC0) return 5'b0;
    s = (int'(p) - 'hC0) / 4;
    en = (s < 4) ? m13[s + 4] : m12[s - 4];
    rom = m11[s / 4 + 4];
    mode = m11[s / 4];
    if (en && rom) return {1'b1, 2'd1, !mode ? 2'd0 : (m11[3] ? 2'd1 : 2'd2)};
    return {1'b1, (p >= 8'hE0) ? 2'd3 : 2'd2, 2'd0};
  endfunction

  function automatic bit expect_high();
    bit h = 1'b0;
    for (int s = 4; s < 12; s++) if (m12[s - 4] && m11[s / 4 + 4]) h = 1'b1;
    return h;
  endfunction

  task automatic sweep_pages();
    logic [4:0] e;
    string tag;
    for (int p = 0; p < 256; p++) begin
      mem_page = 8'(p);
      #1;
      e = expect_attr(8'(p));
      if (p >= 'hF0) tag = m11[7] ? "R4 top area" : "R5 top area";
      else if (p < 'hC0) tag = "R10 unclaimed";
      else tag = (e[3:2] == 2'd1) ? "R6 shadowed segment" : "R7 plain segment";
      chk({claimed, rd_src, wr_tgt} == e, tag, {claimed, rd_src, wr_tgt}, e);
    end
    chk(shadow_high == expect_high(), "R8 shadow_high", shadow_high, expect_high());
    chk(halt_reset_en == m14[6], "R9 halt bit", halt_reset_en, m14[6]);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    checks++; fails++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    logic [7:0] v;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R3 reset state
    chk(shadow_high == 1'b0, "R3 shadow_high reset", shadow_high, 0);
    chk(halt_reset_en == 1'b0, "R3 halt reset", halt_reset_en, 0);
    rdreg(8'h10, v); chk(v == 8'h3F, "R3 reg10", v, 8'h3F);
    rdreg(8'h11, v); chk(v == 8'hF0, "R3 reg11", v, 8'hF0);
    rdreg(8'h12, v); chk(v == 8'h00, "R3 reg12", v, 0);
    rdreg(8'h13, v); chk(v == 8'h00, "R3 reg13", v, 0);
    rdreg(8'h14, v); chk(v == 8'h00, "R3 reg14", v, 0);
    sweep_pages();

    // R1 port decode
    io_addr = IDXP; #2 chk(io_rdata == 8'hFF, "R1 index port read", io_rdata, 8'hFF);
    io_addr = 16'h0023; #2 chk(io_rdata == 8'hFF, "R1 other port read", io_rdata, 8'hFF);
    io_addr = 16'h0124; #2 chk(io_rdata == 8'hFF, "R1 alias port read", io_rdata, 8'hFF);
    io_addr = 16'h0080;

    // R2 write window
    setreg(8'h15, 8'hAA); rdreg(8'h15, v); chk(v == 8'h00, "R2 index 15 ignored", v, 0);
    setreg(8'h0F, 8'h55); rdreg(8'h0F, v); chk(v == 8'h00, "R2 index 0F ignored", v, 0);
    setreg(8'h10, 8'h12); rdreg(8'h10, v); chk(v == 8'h12, "R2 index 10 stored", v, 8'h12);
    setreg(8'h13, 8'hC3); rdreg(8'h13, v); chk(v == 8'hC3, "R2 index 13 stored", v, 8'hC3);

    // R9 halt bit
    setreg(8'h14, 8'h40); chk(halt_reset_en == 1'b1, "R9 halt set", halt_reset_en, 1);
    setreg(8'h14, 8'h80); chk(halt_reset_en == 1'b0, "R9 halt clear", halt_reset_en, 0);

    // R11 write timing
    setreg(8'h11, 8'h00);
    io_write(IDXP, 8'h11);
    mem_page = 8'hF0;
    @(negedge clk);
    io_wr = 1'b1; io_addr = DATP; io_wdata = 8'h80;
    #5 chk(rd_src == 2'd1, "R11 before edge", rd_src, 1);
    @(posedge clk);
    #5 chk(rd_src == 2'd3, "R11 after edge", rd_src, 3);
    @(negedge clk);
    io_wr = 1'b0; io_addr = 16'h0080;
    m11 = 8'h80;

    // corner configs
    setreg(8'h11, 8'hFF); setreg(8'h12, 8'hFF); setreg(8'h13, 8'hF0); setreg(8'h14, 8'h00);
    sweep_pages();
    setreg(8'h11, 8'h77); sweep_pages();
    setreg(8'h11, 8'h7F); setreg(8'h14, 8'h80); sweep_pages();
    setreg(8'h11, 8'h1F); setreg(8'h12, 8'h00); sweep_pages();

    for (int k = 0; k < 48; k++) begin
      setreg(8'h11, 8'(k * 37 + 11));
      setreg(8'h12, 8'(k * 91 + 5));
      setreg(8'h13, 8'(k * 53 + 200));
      setreg(8'h14, 8'(k * 64));
      sweep_pages();
    end

    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule